// File: doc/BRIEF.md
# Configurable Registered/Combinational Output Cell Bank

This block is a bank of identical output cells, ten by default, placed after the OR groups of a sum-of-products logic array. Each cell receives its own sum, its own output-enable term and a four-bit configuration word. All cells share the following inputs:

- a clock source, picked from a dedicated clock pin or a clock product term, in true or complement form;
- a synchronous preset term;
- an asynchronous clear term.

For each cell the configuration word decides three things:

- whether the pad shows the registered or the combinational sum;
- whether the pad is active-high or active-low;
- which signal the cell returns to the array as feedback.

The pad is modelled as an output value plus an output enable. The level outside the pad, `pin_in`, is an input to the bank. When the pad is enabled, the resolved pad level is the cell's own drive. When it is disabled, the resolved level is `pin_in`. This lets a cell serve as an output, an input or a bidirectional pin.

The whole bank runs on one system clock. The selected device clock is sampled, and a small two-state machine finds its active edge. The states are CK_LOW and CK_HIGH:

- CK_HIGH to CK_LOW when the selected clock is sampled low.
- CK_LOW to CK_HIGH when it is sampled high. This transition raises a one-cycle load strobe.

Reset enters CK_HIGH, so a clock that is already high at reset release does not count as an edge. On the strobe each register takes the preset value or its sum. The clear term forces every register output low at once and clears the stored bit at the next system clock edge. A power-on reset clears all registers.

Top module: `io_cell_bank`

## Requirements
- R1: While `rst_n` is low, every register holds 0: a registered active-high cell drives 0, a registered active-low cell drives 1, and register feedback reads 0.
- R2: A register loads its cell's `or_sum` on the system clock edge at which the selected clock is first sampled active (state CK_LOW to CK_HIGH). It keeps its value at every other system clock edge.
- R3: Clock selection is shared by all cells. `clk_use_term`=1 takes `clk_pterm` and 0 takes `dev_clk_pin`. `clk_invert`=1 makes the falling edge of that source the active edge, and a rising edge then loads nothing.
- R4: When `sync_preset` is 1 at an active clock edge and clear is 0, the register becomes 1 whatever its sum.
- R5: While `async_clear` is 1, register outputs read 0 in the same cycle, without any clock edge. The stored bit is 0 once clear is released.
- R6: When preset and clear are both 1 at an active edge, the register ends at 0.
- R7: Configuration bit 0 gives polarity: 1 drives the pad with the true value, 0 with its complement. This holds for both output types.
- R8: Configuration bit 1 gives output type: 1 drives the pad from the register, 0 drives it from `or_sum` combinationally, in the same cycle.
- R9: `pad_oe` equals `oe_term` for each cell. The resolved pad level is `pad_out` when enabled and `pin_in` when disabled.
- R10: Configuration bits [3:2] select the feedback:
  - 00: register Q for registered cells, resolved pad level for combinational cells.
  - 01: register Q.
  - 10: resolved pad level.
  - 11: the uninverted `or_sum`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples everything |
| rst_n | input | 1 | Active-low power-on reset, clears all registers |
| dev_clk_pin | input | 1 | Dedicated device clock pin |
| clk_pterm | input | 1 | Clock product term |
| clk_use_term | input | 1 | 1 selects `clk_pterm`, 0 selects `dev_clk_pin` |
| clk_invert | input | 1 | 1 makes the falling edge active |
| sync_preset | input | 1 | Shared synchronous preset term |
| async_clear | input | 1 | Shared asynchronous clear term |
| or_sum | input | N_CELLS | Per-cell OR-group sum |
| oe_term | input | N_CELLS | Per-cell output-enable term |
| cell_cfg | input | 4*N_CELLS | Per-cell configuration, cell i at [4i+3:4i] |
| pin_in | input | N_CELLS | External level seen at each pad |
| pad_out | output | N_CELLS | Value driven toward each pad |
| pad_oe | output | N_CELLS | Pad drive enable |
| fb_out | output | N_CELLS | Feedback returned to the array |

## Verification
The main function is tried with the following patterns:

- **Sum changes with no clock edge.** This separates the combinational path, which follows at once, from the registered path, which must hold.
- **Clock pulses on the pin while the product term is selected, and the reverse.** These show whether the source multiplexer is honoured.
- **Rising and falling edges with inversion on.** These show whether the polarity of the edge is honoured.
- **Preset alone, clear alone, then both together.** These expose the priority order and show whether clear acts without a clock.
- **Different pad levels with the enable on and off, across each feedback code.** These tell the four feedback sources apart, because Q, the sum and the pad are held at different values.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int CFG_W = 4;

    typedef enum logic [1:0] {
        FB_AUTO = 2'b00,
        FB_REG  = 2'b01,
        FB_PIN  = 2'b10,
        FB_SUM  = 2'b11
    } fb_sel_e;

    typedef struct packed {
        fb_sel_e fb;
        logic    registered;
        logic    active_high;
    } cell_cfg_t;

    typedef enum logic {
        CK_LOW  = 1'b0,
        CK_HIGH = 1'b1
    } ck_state_e;

endpackage

// File: rtl/oc_clk_edge.sv
module oc_clk_edge
    import oc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_pin,
    input  logic clk_term,
    input  logic use_term,
    input  logic invert,
    output logic fire
);

    ck_state_e st, st_nxt;
    logic      sel;

    assign sel = (use_term ? clk_term : clk_pin) ^ invert;

    // state register; reset in CK_HIGH so an already-high clock is no edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CK_HIGH;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        fire   = 1'b0;
        unique case (st)
            CK_LOW: begin
                if (sel) begin
                    st_nxt = CK_HIGH;
                    fire   = 1'b1;
                end
            end
            CK_HIGH: begin
                if (!sel) st_nxt = CK_LOW;
            end
        endcase
    end

    AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R3

endmodule

// File: rtl/oc_state_reg.sv
module oc_state_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic preset,
    input  logic clear,
    input  logic d,
    output logic q
);

    logic q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_r <= 1'b0;
        else if (clear)  q_r <= 1'b0;
        else if (fire)   q_r <= preset ? 1'b1 : d;
    end

    // clear masks the stored bit at once, without waiting for an edge
    assign q = q_r & ~clear;

    AST_CLEAR_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !q_r); // R6
    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && preset && !clear) |=> q_r); // R4
    AST_LOAD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !preset && !clear) |=> (q_r == $past(d))); // R2
    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !clear) |=> $stable(q_r)); // R2

endmodule

// File: rtl/oc_out_cell.sv
module oc_out_cell
    import oc_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      sum,
    input  logic      q,
    input  logic      oe_term,
    input  logic      pin_in,
    output logic      pad_out,
    output logic      pad_oe,
    output logic      fb
);

    logic core;
    logic pad_level;

    always_comb begin
        core      = cfg.registered ? q : sum;
        pad_out   = cfg.active_high ? core : ~core;
        pad_oe    = oe_term;
        pad_level = oe_term ? pad_out : pin_in;
        unique case (cfg.fb)
            FB_AUTO: fb = cfg.registered ? q : pad_level;
            FB_REG:  fb = q;
            FB_PIN:  fb = pad_level;
            FB_SUM:  fb = sum;
        endcase
    end

endmodule

// File: rtl/io_cell_bank.sv
module io_cell_bank
    import oc_pkg::*;
#(
    parameter int N_CELLS = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dev_clk_pin,
    input  logic                       clk_pterm,
    input  logic                       clk_use_term,
    input  logic                       clk_invert,
    input  logic                       sync_preset,
    input  logic                       async_clear,
    input  logic [N_CELLS-1:0]         or_sum,
    input  logic [N_CELLS-1:0]         oe_term,
    input  logic [N_CELLS*CFG_W-1:0]   cell_cfg,
    input  logic [N_CELLS-1:0]         pin_in,
    output logic [N_CELLS-1:0]         pad_out,
    output logic [N_CELLS-1:0]         pad_oe,
    output logic [N_CELLS-1:0]         fb_out
);

    logic load_strobe;

    oc_clk_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_pin  (dev_clk_pin),
        .clk_term (clk_pterm),
        .use_term (clk_use_term),
        .invert   (clk_invert),
        .fire     (load_strobe)
    );

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        cell_cfg_t cfg_i;
        logic      q_i;

        assign cfg_i = cell_cfg_t'(cell_cfg[i*CFG_W +: CFG_W]);

        oc_state_reg u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .fire   (load_strobe),
            .preset (sync_preset),
            .clear  (async_clear),
            .d      (or_sum[i]),
            .q      (q_i)
        );

        oc_out_cell u_out (
            .cfg     (cfg_i),
            .sum     (or_sum[i]),
            .q       (q_i),
            .oe_term (oe_term[i]),
            .pin_in  (pin_in[i]),
            .pad_out (pad_out[i]),
            .pad_oe  (pad_oe[i]),
            .fb      (fb_out[i])
        );

        AST_HIZ_PIN_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_term[i] && cfg_i.fb == FB_PIN) |-> (fb_out[i] == pin_in[i])); // R9
        AST_SUM_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_i.fb == FB_SUM) |-> (fb_out[i] == or_sum[i])); // R10
    end

endmodule

// File: tb/io_cell_bank_bench.sv
`timescale 1ns/1ps
module io_cell_bank_bench;

    localparam int N = 10;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           dev_clk_pin, clk_pterm, clk_use_term, clk_invert;
    logic           sync_preset, async_clear;
    logic [N-1:0]   or_sum, oe_term, pin_in;
    logic [4*N-1:0] cell_cfg;
    logic [N-1:0]   pad_out, pad_oe, fb_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    io_cell_bank #(.N_CELLS(N)) u_io_cell_bank (
        .clk(clk), .rst_n(rst_n), .dev_clk_pin(dev_clk_pin), .clk_pterm(clk_pterm),
        .clk_use_term(clk_use_term), .clk_invert(clk_invert),
        .sync_preset(sync_preset), .async_clear(async_clear),
        .or_sum(or_sum), .oe_term(oe_term), .cell_cfg(cell_cfg), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
    );

    task automatic check(input string req, input string what, input logic [N-1:0] got,
                         input logic [N-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pin_pulse();
        dev_clk_pin = 1'b1; step();
        dev_clk_pin = 1'b0; step();
    endtask

    task automatic term_pulse();
        clk_pterm = 1'b1; step();
        clk_pterm = 1'b0; step();
    endtask

    task automatic t_reset();
        check("R1", "reg active-high pad", N'(pad_out[0]), N'(1'b0));
        check("R1", "reg active-low pad", N'(pad_out[3]), N'(1'b1));
        check("R1", "reg feedback", N'(fb_out[0]), N'(1'b0));
    endtask

    task automatic t_comb();
        or_sum = '1; #1;
        check("R8", "comb high follows sum", N'(pad_out[1]), N'(1'b1));
        check("R7", "comb low inverts", N'(pad_out[2]), N'(1'b0));
        or_sum = '0; #1;
        check("R8", "comb high follows sum 0", N'(pad_out[1]), N'(1'b0));
        check("R7", "comb low inverts 0", N'(pad_out[2]), N'(1'b1));
        or_sum = '1; step();
        check("R2", "no edge no load", N'(pad_out[0]), N'(1'b0));
    endtask

    task automatic t_load();
        or_sum = '1; pin_pulse();
        check("R2", "load 1", N'(pad_out[0]), N'(1'b1));
        check("R7", "reg active-low", N'(pad_out[3]), N'(1'b0));
        check("R10", "auto fb is Q", N'(fb_out[0]), N'(1'b1));
        or_sum = '0; step();
        check("R2", "hold without edge", N'(pad_out[0]), N'(1'b1));
        pin_pulse();
        check("R2", "load 0", N'(pad_out[0]), N'(1'b0));
    endtask

    task automatic t_preset();
        or_sum = '0; sync_preset = 1'b1; pin_pulse(); sync_preset = 1'b0;
        check("R4", "preset sets Q", N'(pad_out[0]), N'(1'b1));
    endtask

    task automatic t_clear();
        async_clear = 1'b1; #1;
        check("R5", "clear immediate high", N'(pad_out[0]), N'(1'b0));
        check("R5", "clear immediate low", N'(pad_out[3]), N'(1'b1));
        step(); async_clear = 1'b0; #1;
        check("R5", "stays cleared", N'(pad_out[0]), N'(1'b0));
    endtask

    task automatic t_prio();
        or_sum = '1; sync_preset = 1'b1; async_clear = 1'b1;
        pin_pulse();
        check("R6", "clear over preset", N'(pad_out[0]), N'(1'b0));
        async_clear = 1'b0; sync_preset = 1'b0; step();
        check("R6", "stored bit cleared", N'(pad_out[0]), N'(1'b0));
    endtask

    task automatic t_inv();
        or_sum = '0; dev_clk_pin = 1'b1; step();
        clk_invert = 1'b1; step();
        or_sum = '1; step();
        check("R3", "inverted: high level no load", N'(pad_out[0]), N'(1'b0));
        dev_clk_pin = 1'b0; step();
        check("R3", "inverted: falling loads", N'(pad_out[0]), N'(1'b1));
        or_sum = '0; dev_clk_pin = 1'b1; step();
        check("R3", "inverted: rising ignored", N'(pad_out[0]), N'(1'b1));
        dev_clk_pin = 1'b0; step();
        clk_invert = 1'b0; step();
    endtask

    task automatic t_term();
        clk_use_term = 1'b1; step();
        or_sum = '1; pin_pulse();
        check("R3", "pin ignored when term selected", N'(pad_out[0]), N'(1'b0));
        term_pulse();
        check("R3", "term edge loads", N'(pad_out[0]), N'(1'b1));
        clk_use_term = 1'b0; step();
    endtask

    task automatic t_oe();
        or_sum = '1; oe_term = '0; pin_in = '0; #1;
        check("R9", "pad_oe follows term off", pad_oe, '0);
        check("R9", "hi-z fb reads pin 0", N'(fb_out[1]), N'(1'b0));
        pin_in = '1; #1;
        check("R9", "hi-z fb reads pin 1", N'(fb_out[1]), N'(1'b1));
        oe_term = '1; pin_in = '0; #1;
        check("R9", "pad_oe follows term on", pad_oe, '1);
        check("R9", "driven fb reads own drive", N'(fb_out[1]), N'(1'b1));
        or_sum = '0; #1;
        check("R9", "driven fb follows sum", N'(fb_out[1]), N'(1'b0));
    endtask

    task automatic t_fb();
        or_sum = '0; pin_pulse();
        or_sum = '1; #1;
        check("R10", "code 11 gives sum", N'(fb_out[4]), N'(1'b1));
        check("R10", "auto registered gives Q", N'(fb_out[0]), N'(1'b0));
        check("R10", "code 01 gives Q", N'(fb_out[6]), N'(1'b0));
        check("R10", "code 01 pad still comb", N'(pad_out[6]), N'(1'b1));
        check("R10", "code 10 driven pad", N'(fb_out[5]), N'(1'b0));
        oe_term[5] = 1'b0; pin_in[5] = 1'b1; #1;
        check("R10", "code 10 external pin", N'(fb_out[5]), N'(1'b1));
    endtask

    initial begin
        rst_n = 1'b0;
        dev_clk_pin = 1'b0; clk_pterm = 1'b0; clk_use_term = 1'b0; clk_invert = 1'b0;
        sync_preset = 1'b0; async_clear = 1'b0;
        or_sum = '0; oe_term = '1; pin_in = '0;
        cell_cfg = '0;
        cell_cfg[3:0]   = 4'b0011;
        cell_cfg[7:4]   = 4'b0001;
        cell_cfg[11:8]  = 4'b0000;
        cell_cfg[15:12] = 4'b0010;
        cell_cfg[19:16] = 4'b1111;
        cell_cfg[23:20] = 4'b1011;
        cell_cfg[27:24] = 4'b0101;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1; step();
        t_comb();
        t_load();
        t_preset();
        t_clear();
        t_prio();
        t_inv();
        t_term();
        t_oe();
        t_fb();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule